// File: doc/BRIEF.md
# Latched Interrupt Arbiter with Mask

This block sits between a processor core and its interrupt sources: a set of hardware request lines, a strobe for the software-interrupt instruction, and a break request. When the core signals that it is starting interrupt processing, the block arbitrates once among the eligible sources. It latches the single winner and presents a fixed vector code, which the core uses to pick the vector to fetch. The winner stays latched and its code stays unchanged until the core reports that service has finished, or until the interrupt mask is cleared. A request that arrives later cannot displace the latched one, whatever its priority.

The block also holds the interrupt mask bit. Hardware lines take part in arbitration only while the mask is clear. Break and software interrupt ignore the mask. Interrupt entry sets the mask and keeps a copy of its previous value. The return-from-interrupt strobe copies that saved value back. When a hardware line's service completes, the block acknowledges that line with a one-cycle pulse.

Top module: `irq_latch_arbiter`

## Requirements
- R1: After reset, `irq_pending` is 0, `vector_code` is 0, `ack` is all zeros and `mask` is 1.
- R2: On a clock edge where `start_proc` is 1, nothing is latched and an eligible source exists, the block latches the winner. From the next cycle, `irq_pending` is 1 and `vector_code` holds the winner's code. The codes are: 0 for idle, 1 for break, 2 for software interrupt, and 3+i for hardware line i.
- R3: The fixed priority is break, then software interrupt, then hardware lines. Among hardware lines, the lower index wins.
- R4: A hardware line is eligible only while `mask` is 0. Break and software interrupt are eligible whatever the mask.
- R5: On entry, `mask` becomes 1 in the next cycle, and the mask value from before entry is saved.
- R6: While a request is latched, `vector_code` stays stable and `start_proc` is ignored. New requests of any priority do not replace the latched one.
- R7: `serviced` while latched clears `irq_pending` and `vector_code` in the next cycle. If the latched source is hardware line i, `ack[i]` is 1 for exactly that one cycle. No ack is given for break or software interrupt.
- R8: `mask_clr` sets `mask` to 0 in the next cycle. If a request is latched, it is released with no ack.
- R9: `rti_mask_restore` loads `mask` with the value saved at the most recent entry.
- R10: `start_proc` with no eligible source changes nothing.
- R11: When several mask updates fall in the same cycle, entry takes precedence over `mask_clr`, and `mask_clr` takes precedence over `rti_mask_restore`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_LINES | Hardware interrupt request lines, level |
| swi | input | 1 | Software-interrupt request |
| brk | input | 1 | Break request |
| start_proc | input | 1 | Core begins interrupt processing; arbitration point |
| serviced | input | 1 | Latched interrupt has been serviced |
| mask_clr | input | 1 | Clear the mask bit |
| rti_mask_restore | input | 1 | Return from interrupt: restore the saved mask |
| vector_code | output | CODE_W | Latched vector code (0 when idle) |
| irq_pending | output | 1 | A request is latched |
| ack | output | N_LINES | One-cycle acknowledge for the serviced hardware line |
| mask | output | 1 | Current interrupt mask bit |

## Verification
A wrong latched state shows up the cycle after the faulty edge. `irq_pending` or `vector_code` disagrees with the reference, or the code changes while the request should be held. A corrupt saved mask stays hidden until the next `rti_mask_restore`, and only then appears on `mask`. Because of that, the stimulus pairs entries with restores from both mask values. A wrong ack decode shows up only on the single cycle after `serviced`, so `ack` is compared on every cycle, including for each hardware line index.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int CODE_IDLE  = 0;
   localparam int CODE_BRK   = 1;
   localparam int CODE_SWI   = 2;
   localparam int CODE_LINE0 = 3;

   function automatic int code_width(input int n_lines);
      return $clog2(n_lines + CODE_LINE0);
   endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_arb_pkg::*;
#(
   parameter int N_LINES   = 8,
   parameter int CODE_W    = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N_LINES-1:0] req,
   input  logic               swi,
   input  logic               brk,
   input  logic               mask,
   output logic [CODE_W-1:0]  code
);
   logic [CODE_W-1:0] hw_code;

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            hw_code = CODE_W'(CODE_IDLE);
            for (int i = N_LINES - 1; i >= 0; i--)
               if (req[i]) hw_code = CODE_W'(i + CODE_LINE0);
         end
      end else begin : g_high_first
         always_comb begin
            hw_code = CODE_W'(CODE_IDLE);
            for (int i = 0; i < N_LINES; i++)
               if (req[i]) hw_code = CODE_W'(i + CODE_LINE0);
         end
      end
   endgenerate

   always_comb begin
      if (brk)       code = CODE_W'(CODE_BRK);
      else if (swi)  code = CODE_W'(CODE_SWI);
      else if (mask) code = CODE_W'(CODE_IDLE);
      else           code = hw_code;
   end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic clr,
   input  logic restore,
   output logic mask
);
   logic mask_q;
   logic saved_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= 1'b1;
         saved_q <= 1'b1;
      end else if (enter) begin
         saved_q <= mask_q;
         mask_q  <= 1'b1;
      end else if (clr) begin
         mask_q  <= 1'b0;
      end else if (restore) begin
         mask_q  <= saved_q;
      end
   end

   assign mask = mask_q;

   AST_RESTORE_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (saved_q == $past(mask_q))) else $error("saved mask lost"); // R9
endmodule

// File: rtl/irq_latch_arbiter.sv
module irq_latch_arbiter
   import irq_arb_pkg::*;
#(
   parameter int  N_LINES   = 8,
   parameter bit  LOW_FIRST = 1'b1,
   localparam int CODE_W    = code_width(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req,
   input  logic               swi,
   input  logic               brk,
   input  logic               start_proc,
   input  logic               serviced,
   input  logic               mask_clr,
   input  logic               rti_mask_restore,
   output logic [CODE_W-1:0]  vector_code,
   output logic               irq_pending,
   output logic [N_LINES-1:0] ack,
   output logic               mask
);
   generate
      if (N_LINES < 1) begin : g_bad_lines
         $error("N_LINES must be at least 1");
      end
   endgenerate

   logic [CODE_W-1:0]  pick_code;
   logic [CODE_W-1:0]  code_q;
   logic               pend_q;
   logic [N_LINES-1:0] ack_q;
   logic               take;
   logic               release_now;
   logic               code_is_line;

   irq_prio_pick #(
      .N_LINES   (N_LINES),
      .CODE_W    (CODE_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_pick (
      .req  (req),
      .swi  (swi),
      .brk  (brk),
      .mask (mask),
      .code (pick_code)
   );

   assign take         = start_proc && !pend_q && (pick_code != CODE_W'(CODE_IDLE));
   assign release_now  = pend_q && (serviced || mask_clr);
   assign code_is_line = (code_q >= CODE_W'(CODE_LINE0));

   irq_mask_ctrl u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter   (take),
      .clr     (mask_clr),
      .restore (rti_mask_restore),
      .mask    (mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         code_q <= CODE_W'(CODE_IDLE);
         ack_q  <= '0;
      end else begin
         ack_q <= '0;
         if (take) begin
            pend_q <= 1'b1;
            code_q <= pick_code;
         end else if (release_now) begin
            pend_q <= 1'b0;
            code_q <= CODE_W'(CODE_IDLE);
            if (serviced && code_is_line)
               ack_q <= N_LINES'(1) << (code_q - CODE_W'(CODE_LINE0));
         end
      end
   end

   assign vector_code = code_q;
   assign irq_pending = pend_q;
   assign ack         = ack_q;

   AST_HOLD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !serviced && !mask_clr) |=> (pend_q && $stable(code_q))) else $error("latched code moved"); // R6
   AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> mask) else $error("mask not set on entry"); // R5
   AST_HW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && (code_q >= CODE_W'(CODE_LINE0))) |-> !$past(mask)) else $error("masked line won"); // R4
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_q)) else $error("ack not one-hot"); // R7
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_q) |=> (ack_q == '0)) else $error("ack too long"); // R7
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      release_now |=> !pend_q) else $error("not released"); // R7
   AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_clr && !take) |=> !mask) else $error("mask not cleared"); // R8
endmodule

// File: tb/irq_latch_arbiter_bench.sv
module irq_latch_arbiter_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         swi = 1'b0, brk = 1'b0, start_proc = 1'b0;
   logic         serviced = 1'b0, mask_clr = 1'b0, rti_mask_restore = 1'b0;
   logic [3:0]   vector_code;
   logic         irq_pending;
   logic [N-1:0] ack;
   logic         mask;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_pend = 0, m_code = 0, m_mask = 1, m_saved = 1, m_ack = 0;

   always #4 clk = ~clk;

   irq_latch_arbiter #(.N_LINES(N)) u_irq_latch_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .swi(swi), .brk(brk),
      .start_proc(start_proc), .serviced(serviced), .mask_clr(mask_clr),
      .rti_mask_restore(rti_mask_restore), .vector_code(vector_code),
      .irq_pending(irq_pending), .ack(ack), .mask(mask));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int winner(input int r, input bit s, input bit b, input int mk);
      if (b) return 1;
      if (s) return 2;
      if (mk != 0) return 0;
      for (int i = 0; i < N; i++) if (r[i]) return 3 + i;
      return 0;
   endfunction

   task automatic compare_all();
      chk(int'(irq_pending) == m_pend, "R2 pending", int'(irq_pending), m_pend);
      chk(int'(vector_code) == m_code, "R2 code", int'(vector_code), m_code);
      chk(int'(mask) == m_mask, "R5 mask", int'(mask), m_mask);
      chk(int'(ack) == m_ack, "R7 ack", int'(ack), m_ack);
   endtask

   // one clock: drive at negedge, model next state, compare after edge
   task automatic cyc(input int r, input bit s, input bit b, input bit sp,
                      input bit sv, input bit mc, input bit rr);
      int w, np, nc, nm, ns, na;
      req = N'(r); swi = s; brk = b; start_proc = sp;
      serviced = sv; mask_clr = mc; rti_mask_restore = rr;
      w = winner(r, s, b, m_mask);
      np = m_pend; nc = m_code; nm = m_mask; ns = m_saved; na = 0;
      if (m_pend == 0 && sp && w != 0) begin
         np = 1; nc = w; ns = m_mask; nm = 1;
      end else begin
         if (m_pend != 0 && (sv || mc)) begin
            np = 0; nc = 0;
            if (sv && m_code >= 3) na = 1 << (m_code - 3);
         end
         if (mc) nm = 0;
         else if (rr) nm = m_saved;
      end
      @(posedge clk);
      @(negedge clk);
      m_pend = np; m_code = nc; m_mask = nm; m_saved = ns; m_ack = na;
      compare_all();
   endtask

   task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(irq_pending == 1'b0, "R1 pending", int'(irq_pending), 0);
      chk(vector_code == 4'd0, "R1 code", int'(vector_code), 0);
      chk(ack == '0, "R1 ack", int'(ack), 0);
      chk(mask == 1'b1, "R1 mask", int'(mask), 1);

      // R4: mask set, hw line not eligible -> R10 nothing latched
      cyc(8'h10, 0, 0, 1, 0, 0, 0);
      chk(irq_pending == 1'b0, "R4 masked line ignored", int'(irq_pending), 0);
      // R8 clear mask, R10 empty start
      cyc(0, 0, 0, 1, 0, 1, 0);
      chk(irq_pending == 1'b0 && mask == 1'b0, "R10 empty start", int'(irq_pending), 0);
      // R3 lower index wins
      cyc(8'h14, 0, 0, 1, 0, 0, 0);
      chk(vector_code == 4'd5, "R3 low index", int'(vector_code), 5);
      // R6 break arrives, cannot pre-empt
      cyc(8'hFF, 1, 1, 1, 0, 0, 0);
      chk(vector_code == 4'd5, "R6 hold", int'(vector_code), 5);
      // R7 serviced -> ack line 2
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(ack == 8'h04, "R7 ack line2", int'(ack), 4);
      idle();
      chk(ack == '0, "R7 ack one cycle", int'(ack), 0);
      // R9 restore saved (0)
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk(mask == 1'b0, "R9 restore 0", int'(mask), 0);
      // R3 break over swi, R4 break bypasses (then mask set)
      cyc(8'h01, 1, 1, 1, 0, 0, 0);
      chk(vector_code == 4'd1, "R3 brk first", int'(vector_code), 1);
      // R8 mask_clr releases, no ack
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk(irq_pending == 1'b0 && ack == '0, "R8 release no ack", int'(irq_pending), 0);
      // swi over line with mask set: set mask via entry of swi
      cyc(8'h80, 1, 0, 1, 0, 0, 0);
      chk(vector_code == 4'd2, "R3 swi over line", int'(vector_code), 2);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(ack == '0, "R7 no ack for swi", int'(ack), 0);
      // R4 swi bypasses mask (mask now 1)
      cyc(0, 1, 0, 1, 0, 0, 0);
      chk(vector_code == 4'd2, "R4 swi while masked", int'(vector_code), 2);
      cyc(0, 0, 0, 0, 1, 0, 0);
      // R9 restore: saved was 1
      cyc(0, 0, 0, 0, 0, 0, 1);
      chk(mask == 1'b1, "R9 restore 1", int'(mask), 1);
      // R11 clr beats restore
      cyc(0, 0, 0, 0, 0, 1, 1);
      chk(mask == 1'b0, "R11 clr over restore", int'(mask), 0);
      // R11 entry beats clr
      cyc(8'h80, 0, 0, 1, 0, 1, 0);
      chk(mask == 1'b1 && vector_code == 4'd10, "R11 entry over clr", int'(vector_code), 10);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(ack == 8'h80, "R7 ack line7", int'(ack), 128);
      idle();

      // mixed pseudo-random run against the model
      for (int k = 0; k < 3000; k++) begin
         int r;
         bit s, b, sp, sv, mc, rr;
         r  = int'($urandom_range(0, 255)) & int'($urandom_range(0, 255));
         s  = ($urandom_range(0, 9) == 0);
         b  = ($urandom_range(0, 14) == 0);
         sp = ($urandom_range(0, 2) == 0);
         sv = ($urandom_range(0, 3) == 0);
         mc = ($urandom_range(0, 7) == 0);
         rr = ($urandom_range(0, 5) == 0);
         cyc(r, s, b, sp, sv, mc, rr);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule